// File: doc/BRIEF.md
# Systolic Mesh Matrix Multiplier

This block multiplies two square matrices on a square grid of multiply-accumulate cells, `C = A·B`. Operands flow across the grid. A-values travel down the columns and B-values travel right along the rows. Each cell keeps a private running sum and passes both operands to its neighbours on every step. Operand lanes are staggered in time, so the matching pair `a[i][k]`, `b[k][j]` meets in exactly one cell on exactly one step.

A small built-in feeder produces the staggered lane streams from two matrices presented in parallel. Zero-valid bubbles fill the slots where a lane has no operand. A caller can instead drive the edge lanes directly, each lane with its own valid flag.

A run starts with a one-cycle start pulse. The run lasts `3N-2` steps and ends with a one-cycle done pulse. All `N²` sums are then readable in parallel and hold until the next start.

Top module: `mesh_matmul`

## Requirements
- R1: After reset `done` is 0 and every result word reads 0.
- R2: In the cycle after `start` is sampled high, every result word reads 0, whatever the earlier run left behind.
- R3: Step 1 is the cycle after the start cycle. At step `s`, with the feeder selected (`use_lanes`=0), top lane `l` carries `a[l][s-1-l]` and left lane `r` carries `b[s-1-r][r]`, each valid only when that index lies in `0..N-1`. Element `(i,k)` of `mat_a` sits at bits `(i*N+k)*DW +: DW`, and element `(k,j)` of `mat_b` sits at `(k*N+j)*DW +: DW`.
- R4: In feeder mode the A operand and the B operand arriving at any cell are either both valid or both invalid, on every step.
- R5: At the end of a run, result word `(i,j)`, at bits `(i*N+j)*AW +: AW`, equals the unsigned sum over `k` of `a[i][k]*b[k][j]`. This word is held by the cell at grid row `j`, column `i`.
- R6: `done` goes high exactly `3N-1` cycles after the start cycle (one cycle after step `3N-2`) and stays high for one cycle only.
- R7: After `done`, the result words do not change until the next `start`, even if the matrices or lanes change.
- R8: With `use_lanes`=1 the cells take `top_lane`/`left_lane` (lane `l` at bits `l*DW +: DW`). A lane word whose valid bit is 0 has no effect on any sum.
- R9: A `start` pulse during a run abandons that run, clears all sums and begins a fresh run timed from the new pulse.
- R10: The accumulator width holds N full-scale products: with every operand at `2^DW-1` each result equals `N*(2^DW-1)^2`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Clears sums and begins a run |
| use_lanes | input | 1 | 1: edge lanes come from the ports; 0: from the feeder |
| mat_a | input | N*N*DW | Matrix A, row-major |
| mat_b | input | N*N*DW | Matrix B, row-major |
| top_lane | input | N*DW | External A operands, one per grid column |
| top_vld | input | N | Valid flags for `top_lane` |
| left_lane | input | N*DW | External B operands, one per grid row |
| left_vld | input | N | Valid flags for `left_lane` |
| result | output | N*N*AW | All sums of C, row-major |
| done | output | 1 | One-cycle pulse when the run is complete |

## Verification
Embedded assertions check on every cycle the properties that hold at all times:
- in feeder mode, the two operands reaching each cell are always paired;
- `done` is a single-cycle pulse that can only follow the final step;
- a start always leaves the sums cleared;
- the sums hold steady between runs.

Some behaviour can only be shown by the bench's scenarios:
- the correctness of the products for particular matrices;
- the exact cycle count to `done`;
- the effect of invalid external lane words;
- a restart in mid-run;
- full-scale accumulation.

// File: rtl/mesh_matmul.sv
module mesh_matmul #(
  parameter int N  = 4,
  parameter int DW = 8,
  parameter int AW = 2 * DW + $clog2(N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              use_lanes,
  input  logic [N*N*DW-1:0] mat_a,
  input  logic [N*N*DW-1:0] mat_b,
  input  logic [N*DW-1:0]   top_lane,
  input  logic [N-1:0]      top_vld,
  input  logic [N*DW-1:0]   left_lane,
  input  logic [N-1:0]      left_vld,
  output logic [N*N*AW-1:0] result,
  output logic              done
);
  localparam int LAST = 3 * N - 2;
  localparam int SW   = $clog2(LAST + 1) + 1;
  localparam int IW   = (N > 1) ? $clog2(N) : 1;

  logic [SW-1:0] step;
  logic          running;

  logic [DW-1:0] am [N][N];
  logic [DW-1:0] bm [N][N];
  logic [DW-1:0] lane_a [N];
  logic [DW-1:0] lane_b [N];
  logic          lane_av [N];
  logic          lane_bv [N];

  logic [DW-1:0] a_q  [N][N];
  logic [DW-1:0] b_q  [N][N];
  logic          av_q [N][N];
  logic          bv_q [N][N];
  logic [DW-1:0] a_in [N][N];
  logic [DW-1:0] b_in [N][N];
  logic          av_in [N][N];
  logic          bv_in [N][N];
  logic [AW-1:0] acc  [N][N];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step    <= '0;
      running <= 1'b0;
      done    <= 1'b0;
    end else if (start) begin
      step    <= SW'(1);
      running <= 1'b1;
      done    <= 1'b0;
    end else if (running) begin
      if (step == SW'(LAST)) begin
        step    <= '0;
        running <= 1'b0;
        done    <= 1'b1;
      end else begin
        step <= step + SW'(1);
      end
    end else begin
      done <= 1'b0;
    end
  end

  for (genvar gi = 0; gi < N; gi++) begin : g_unpack_row
    for (genvar gk = 0; gk < N; gk++) begin : g_unpack_col
      assign am[gi][gk] = mat_a[(gi*N+gk)*DW +: DW];
      assign bm[gi][gk] = mat_b[(gi*N+gk)*DW +: DW];
    end
  end

  for (genvar gl = 0; gl < N; gl++) begin : g_lane
    logic [SW-1:0] kidx;
    logic          f_ok;
    logic [DW-1:0] fa, fb;
    assign kidx = step - SW'(gl + 1);
    assign f_ok = running && (step > SW'(gl)) && (kidx < SW'(N));
    assign fa   = f_ok ? am[gl][kidx[IW-1:0]] : '0;
    assign fb   = f_ok ? bm[kidx[IW-1:0]][gl] : '0;
    assign lane_a[gl]  = use_lanes ? top_lane[gl*DW +: DW]  : fa;
    assign lane_b[gl]  = use_lanes ? left_lane[gl*DW +: DW] : fb;
    assign lane_av[gl] = running && (use_lanes ? top_vld[gl]  : f_ok);
    assign lane_bv[gl] = running && (use_lanes ? left_vld[gl] : f_ok);
  end

  for (genvar r = 0; r < N; r++) begin : g_row
    for (genvar c = 0; c < N; c++) begin : g_col
      if (r == 0) begin : g_top
        assign a_in[r][c]  = lane_a[c];
        assign av_in[r][c] = lane_av[c];
      end else begin : g_inner_a
        assign a_in[r][c]  = a_q[r-1][c];
        assign av_in[r][c] = av_q[r-1][c];
      end
      if (c == 0) begin : g_left
        assign b_in[r][c]  = lane_b[r];
        assign bv_in[r][c] = lane_bv[r];
      end else begin : g_inner_b
        assign b_in[r][c]  = b_q[r][c-1];
        assign bv_in[r][c] = bv_q[r][c-1];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          a_q[r][c]  <= '0;
          b_q[r][c]  <= '0;
          av_q[r][c] <= 1'b0;
          bv_q[r][c] <= 1'b0;
          acc[r][c]  <= '0;
        end else if (start) begin
          av_q[r][c] <= 1'b0;
          bv_q[r][c] <= 1'b0;
          acc[r][c]  <= '0;
        end else if (running) begin
          a_q[r][c]  <= a_in[r][c];
          b_q[r][c]  <= b_in[r][c];
          av_q[r][c] <= av_in[r][c];
          bv_q[r][c] <= bv_in[r][c];
          if (av_in[r][c] && bv_in[r][c])
            acc[r][c] <= acc[r][c] + AW'(a_in[r][c]) * AW'(b_in[r][c]);
        end
      end

      assign result[(c*N+r)*AW +: AW] = acc[r][c];

      assert_operands_paired_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !use_lanes) |-> (av_in[r][c] == bv_in[r][c]));
    end
  end

  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_after_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !start && step == SW'(LAST)) |=> done);

  assert_done_not_running_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !running);

  assert_start_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (result == '0));

  assert_hold_between_runs_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !start) |=> $stable(result));
endmodule

// File: tb/test_mesh_matmul.sv
module test_mesh_matmul;
  localparam int N  = 4;
  localparam int DW = 8;
  localparam int AW = 2 * DW + $clog2(N);
  localparam int CYC = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic              use_lanes = 1'b0;
  logic [N*N*DW-1:0] mat_a = '0;
  logic [N*N*DW-1:0] mat_b = '0;
  logic [N*DW-1:0]   top_lane = '0;
  logic [N-1:0]      top_vld = '0;
  logic [N*DW-1:0]   left_lane = '0;
  logic [N-1:0]      left_vld = '0;
  logic [N*N*AW-1:0] result;
  logic              done;

  int ma [N][N];
  int mb [N][N];
  int total = 0;
  int fails = 0;
  bit finished = 0;

  always #(CYC/2) clk = ~clk;

  mesh_matmul #(.N(N), .DW(DW)) i_mesh_matmul (
    .clk(clk), .rst_n(rst_n), .start(start), .use_lanes(use_lanes),
    .mat_a(mat_a), .mat_b(mat_b), .top_lane(top_lane), .top_vld(top_vld),
    .left_lane(left_lane), .left_vld(left_vld), .result(result), .done(done)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic pack_mats();
    for (int i = 0; i < N; i++)
      for (int k = 0; k < N; k++) begin
        mat_a[(i*N+k)*DW +: DW] = DW'(ma[i][k]);
        mat_b[(i*N+k)*DW +: DW] = DW'(mb[i][k]);
      end
  endtask

  function automatic longint ref_c(input int i, input int j);
    longint s = 0;
    for (int k = 0; k < N; k++) s += longint'(ma[i][k]) * longint'(mb[k][j]);
    return s;
  endfunction

  task automatic check_results(input string tag);
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++)
        chk(tag, longint'(result[(i*N+j)*AW +: AW]), ref_c(i, j));
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_done(input string tag);
    int cnt = 1;
    while (!done && cnt < 100) begin @(negedge clk); cnt++; end
    chk(tag, cnt, 3 * N - 1);
    @(negedge clk);
    chk(tag, done, 0);
  endtask

  task automatic test_reset();
    chk("R1 done", done, 0);
    chk("R1 result", (result == '0), 1);
  endtask

  task automatic test_feeder(input string tag);
    use_lanes = 1'b0;
    pack_mats();
    pulse_start();
    chk("R2 cleared", (result == '0), 1);
    wait_done({"R6 ", tag});
    check_results({"R5 ", tag});
  endtask

  task automatic test_hold();
    logic [N*N*AW-1:0] snap = result;
    mat_a = ~mat_a;
    use_lanes = 1'b1;
    top_vld = '1; left_vld = '1;
    top_lane = '1; left_lane = '1;
    repeat (6) @(negedge clk);
    chk("R7 hold", (result == snap), 1);
    top_vld = '0; left_vld = '0;
    use_lanes = 1'b0;
    mat_a = ~mat_a;
  endtask

  task automatic drive_step(input int s);
    for (int l = 0; l < N; l++) begin
      int k = s - 1 - l;
      if (k >= 0 && k < N) begin
        top_lane[l*DW +: DW]  = DW'(ma[l][k]);
        left_lane[l*DW +: DW] = DW'(mb[k][l]);
        top_vld[l] = 1'b1; left_vld[l] = 1'b1;
      end else begin
        top_lane[l*DW +: DW]  = DW'(8'hC3 + l);
        left_lane[l*DW +: DW] = DW'(8'h5A + l);
        top_vld[l] = 1'b0; left_vld[l] = 1'b0;
      end
    end
  endtask

  task automatic test_lanes();
    use_lanes = 1'b1;
    mat_a = '1; mat_b = '1;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int s = 1; s <= 3 * N - 2; s++) begin
      drive_step(s);
      @(negedge clk);
    end
    chk("R6 lanes done", done, 1);
    top_vld = '0; left_vld = '0;
    check_results("R8 lanes, invalid words ignored");
    use_lanes = 1'b0;
  endtask

  task automatic test_restart();
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin ma[i][j] = 200 - i; mb[i][j] = 3 + j; end
    pack_mats();
    pulse_start();
    repeat (4) @(negedge clk);
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin ma[i][j] = i + 2*j; mb[i][j] = 7*i + j + 1; end
    pack_mats();
    pulse_start();
    chk("R9 cleared", (result == '0), 1);
    wait_done("R9 timing");
    check_results("R9 values");
  endtask

  initial begin
    #(CYC * 200000);
    if (!finished) begin
      total++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    #(CYC * 3 + 1);
    @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin ma[i][j] = i * N + j + 1; mb[i][j] = (i == j) ? 1 : 0; end
    test_feeder("R3 identity");
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin ma[i][j] = (3*i + 5*j) % 17; mb[i][j] = (7*i + 2*j + 1) % 23; end
    test_feeder("R3 mixed");
    test_hold();
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin ma[i][j] = 255; mb[i][j] = 255; end
    test_feeder("R10 full scale");
    chk("R10 corner", longint'(result[AW-1:0]), longint'(N) * 255 * 255);
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin ma[i][j] = 10 + i - j; mb[i][j] = 1 + i * j; end
    test_lanes();
    test_restart();

    finished = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule